// File: doc/BRIEF.md
# DMA Read-Channel Launch Sequencer

This block starts one memory-to-stream transfer on a DMA engine without a processor driver. It acts as an AXI4-Lite master on the engine's register port. A one-cycle `start` pulse carries a 32-bit source address and a byte count. The block first checks the byte count. If the count is valid, it performs three register writes in a fixed order: it sets the run bit, then writes the source address, then writes the length. The length write is what launches the transfer, so it always comes last. The block then reads the status register repeatedly until the engine reports idle.

The block runs one register access at a time. Each write completes its address, data and response handshakes before the next access begins. Completion is reported by a one-cycle `done` pulse. A rejected request, or any non-OKAY response, is reported by a one-cycle `err` pulse. While a sequence is running, `busy` is high and new requests are ignored. Scatter-gather and the write channel of the DMA engine are not handled here. Source addresses may be unaligned and are not checked.

Top module: `dma_launch_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `awvalid`, `wvalid`, `bready`, `arvalid` and `rready` are all low.
- R2: An accepted request produces exactly three writes, in this order: offset 0x00, then 0x18, then 0x28, each added to `BASE_ADDR`. No write starts until the previous one has had its B response accepted.
- R3: The first write carries data 0x0000_0001 (run bit at bit 0), and every write has all byte strobes set.
- R4: The second write carries `src_addr` unchanged, including unaligned values such as 0x2000_0003.
- R5: The third and last write carries `byte_len` unchanged.
- R6: A request with `byte_len` equal to 0, or equal to or above 2^26, is handled as follows: `err` is high for exactly one cycle, starting the cycle after `start`; `busy` stays low; and no bus transaction is issued. A length of 2^26-1 is accepted.
- R7: After an OKAY response to the length write, the block reads offset 0x04. It repeats the read until bit 1 (idle) of the returned data is set. It then pulses `done` for one cycle. `done` and `err` are never high together, and a read never overlaps a write.
- R8: A write response or status-read response other than OKAY (00) does two things: no further transaction is issued, and `err` pulses once, two cycles after that response handshake, with `busy` falling in the same cycle.
- R9: `start` is ignored while a sequence runs. This includes the cycle in which the final status response is accepted.
- R10: `busy` rises in the cycle after an accepted `start` and falls in the cycle where `done` or `err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| src_addr | input | 32 | Source buffer address |
| byte_len | input | 32 | Transfer length in bytes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection or response-error pulse |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write address |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |

## Verification
The collision that matters is a new `start` arriving in the same cycle that the final idle status read is accepted. At that edge the block is still busy, but it is about to finish. The bench watches the bus and raises `start` exactly when `rvalid` with the idle bit is about to be taken. Three things must then hold: one `done` pulse appears, no further write follows, and a later, ordinary request is still accepted with the expected write sequence. A second overlap raises `start` in the middle of a sequence with slow polling. The scoreboard then shows whether the second request's address ever reached the bus.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_SRC, S_LEN, S_POLL} seq_state_t;
  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] STAT_OFS = 8'h04;
  localparam logic [7:0] SRC_OFS  = 8'h18;
  localparam logic [7:0] LEN_OFS  = 8'h28;
  localparam int RUN_BIT  = 0;
  localparam int IDLE_BIT = 1;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/dmaseq_len_chk.sv
module dmaseq_len_chk #(
  parameter int LEN_W    = 32,
  parameter int LEN_BITS = 26
) (
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  generate
    if (LEN_BITS >= LEN_W) begin : g_full
      assign ok = |len;
    end else begin : g_trunc
      assign ok = (|len) && !(|len[LEN_W-1:LEN_BITS]);
    end
  endgenerate
endmodule

// File: rtl/dmaseq_axil_wr.sv
module dmaseq_axil_wr
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              fin,
  output logic              fail
);
  logic act;

  always_ff @(posedge clk) begin
    if (rst) begin
      awvalid <= 1'b0;
      wvalid  <= 1'b0;
      bready  <= 1'b0;
      awaddr  <= '0;
      wdata   <= '0;
      wstrb   <= '0;
      act     <= 1'b0;
      fin     <= 1'b0;
      fail    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        act     <= 1'b1;
        awvalid <= 1'b1;
        wvalid  <= 1'b1;
        awaddr  <= addr_in;
        wdata   <= data_in;
        wstrb   <= '1;
      end else begin
        if (awvalid && awready) awvalid <= 1'b0;
        if (wvalid && wready)   wvalid  <= 1'b0;
        if (act && !bready && (!awvalid || awready) && (!wvalid || wready))
          bready <= 1'b1;
        if (bready && bvalid) begin
          bready <= 1'b0;
          act    <= 1'b0;
          fin    <= 1'b1;
          fail   <= (bresp != RESP_OKAY);
        end
      end
    end
  end

  // R2
  resp_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bready |-> (!awvalid && !wvalid));
  // R2
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready) |=> (awvalid && $stable(awaddr)));
  // R2
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));
endmodule

// File: rtl/dmaseq_axil_rd.sv
module dmaseq_axil_rd
  import dmaseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  output logic              fin,
  output logic              fail,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arvalid <= 1'b0;
      rready  <= 1'b0;
      araddr  <= '0;
      fin     <= 1'b0;
      fail    <= 1'b0;
      word    <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        arvalid <= 1'b1;
        araddr  <= addr_in;
      end else if (arvalid && arready) begin
        arvalid <= 1'b0;
        rready  <= 1'b1;
      end
      if (rready && rvalid) begin
        rready <= 1'b0;
        fin    <= 1'b1;
        fail   <= (rresp != RESP_OKAY);
        word   <= rdata;
      end
    end
  end

  // R7
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arvalid && !arready) |=> (arvalid && $stable(araddr)));
  // R7
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    !(arvalid && rready));
endmodule

// File: rtl/dma_launch_seq.sv
module dma_launch_seq
  import dmaseq_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                LEN_W     = 32,
  parameter int                LEN_BITS  = 26,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter bit                POLL_EN   = 1'b1,
  localparam int               STRB_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [LEN_W-1:0]  byte_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  output logic              rready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp
);
  localparam logic [DATA_W-1:0] IDLE_MASK = DATA_W'(1) << IDLE_BIT;
  localparam logic [DATA_W-1:0] RUN_WORD  = DATA_W'(1) << RUN_BIT;

  seq_state_t        state;
  logic              len_ok;
  logic              wr_go, wr_fin, wr_fail;
  logic              rd_go, rd_fin, rd_fail;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;
  logic [ADDR_W-1:0] src_q;
  logic [LEN_W-1:0]  len_q;

  dmaseq_len_chk #(.LEN_W(LEN_W), .LEN_BITS(LEN_BITS)) u_len_chk (
    .len (byte_len),
    .ok  (len_ok)
  );

  dmaseq_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst), .go(wr_go), .addr_in(wr_addr), .data_in(wr_data),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .fin(wr_fin), .fail(wr_fail)
  );

  dmaseq_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .go(rd_go), .addr_in(BASE_ADDR + ADDR_W'(STAT_OFS)),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
    .fin(rd_fin), .fail(rd_fail), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      wr_go   <= 1'b0;
      rd_go   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      src_q   <= '0;
      len_q   <= '0;
    end else begin
      done  <= 1'b0;
      err   <= 1'b0;
      wr_go <= 1'b0;
      rd_go <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (len_ok) begin
            src_q   <= src_addr;
            len_q   <= byte_len;
            busy    <= 1'b1;
            state   <= S_CTRL;
            wr_go   <= 1'b1;
            wr_addr <= BASE_ADDR + ADDR_W'(CTRL_OFS);
            wr_data <= RUN_WORD;
          end else begin
            err <= 1'b1;
          end
        end
        S_CTRL: if (wr_fin) begin
          if (wr_fail) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else begin
            state   <= S_SRC;
            wr_go   <= 1'b1;
            wr_addr <= BASE_ADDR + ADDR_W'(SRC_OFS);
            wr_data <= DATA_W'(src_q);
          end
        end
        S_SRC: if (wr_fin) begin
          if (wr_fail) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else begin
            state   <= S_LEN;
            wr_go   <= 1'b1;
            wr_addr <= BASE_ADDR + ADDR_W'(LEN_OFS);
            wr_data <= DATA_W'(len_q);
          end
        end
        S_LEN: if (wr_fin) begin
          if (wr_fail) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else if (POLL_EN) begin
            state <= S_POLL;
            rd_go <= 1'b1;
          end else begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          end
        end
        S_POLL: if (rd_fin) begin
          if (rd_fail) begin
            state <= S_IDLE; busy <= 1'b0; err <= 1'b1;
          end else if (|(rd_word & IDLE_MASK)) begin
            state <= S_IDLE; busy <= 1'b0; done <= 1'b1;
          end else begin
            rd_go <= 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // R7
  no_rw_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(awvalid && arvalid));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(src_q) && $stable(len_q)));
  // R6
  zero_len_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && byte_len == '0) |=> (err && !busy));
  // R8
  bad_bresp_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (bvalid && bready && bresp != RESP_OKAY) |-> ##2 (err && !busy));
endmodule

// File: tb/dma_launch_seq_tb.sv
module dma_launch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4040_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] src_addr = '0, byte_len = '0;
  logic        busy, done, err;
  logic        awvalid, awready, wvalid, wready, bvalid, bready;
  logic [31:0] awaddr, wdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;
  logic        arvalid, arready, rvalid, rready;
  logic [31:0] araddr, rdata;

  dma_launch_seq #(.BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .byte_len(byte_len),
    .busy(busy), .done(done), .err(err),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp)
  );

  int nchk = 0, nerr = 0;
  int wr_idx = 0, rd_idx = 0, done_cnt = 0, err_cnt = 0;
  int cfg_aw_lat = 0, cfg_w_lat = 0, cfg_bad_b = -1, cfg_bad_r = -1, cfg_idle_at = 0;
  logic [63:0] exp_q[$];
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // AXI4-Lite slave model and scoreboard monitor
  bit aw_got = 0, w_got = 0;
  int aw_cnt = 0, w_cnt = 0;
  logic [31:0] cap_addr, cap_data;
  logic [3:0]  cap_strb;
  always @(posedge clk) begin
    if (rst) begin
      awready <= 0; wready <= 0; bvalid <= 0; bresp <= 0;
      arready <= 0; rvalid <= 0; rdata <= 0; rresp <= 0;
      aw_got = 0; w_got = 0; aw_cnt = 0; w_cnt = 0;
    end else begin
      if (done) done_cnt++;
      if (err) err_cnt++;
      if ((awvalid && aw_got) || (wvalid && w_got))
        check(0, "R2 new write before response", 1, 0);
      if (awvalid && awready) begin
        aw_got = 1; cap_addr = awaddr; awready <= 0; aw_cnt = 0;
      end else if (awvalid && !aw_got && !awready) begin
        if (aw_cnt >= cfg_aw_lat) awready <= 1; else aw_cnt++;
      end
      if (wvalid && wready) begin
        w_got = 1; cap_data = wdata; cap_strb = wstrb; wready <= 0; w_cnt = 0;
      end else if (wvalid && !w_got && !wready) begin
        if (w_cnt >= cfg_w_lat) wready <= 1; else w_cnt++;
      end
      if (bvalid && bready) begin
        bvalid <= 0;
        if (exp_q.size() == 0) check(0, "R2 unexpected write", {cap_addr, cap_data}, 0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check({cap_addr, cap_data} == e, "R2/R3/R4/R5 write addr+data", {cap_addr, cap_data}, e);
        end
        check(cap_strb == 4'hF, "R3 strobes", cap_strb, 4'hF);
        wr_idx++; aw_got = 0; w_got = 0;
      end else if (aw_got && w_got && !bvalid) begin
        bvalid <= 1;
        bresp  <= (wr_idx == cfg_bad_b) ? 2'b10 : 2'b00;
      end
      if (arvalid && arready) begin
        check(araddr == BASE + 32'h4, "R7 status address", araddr, BASE + 32'h4);
        arready <= 0; rvalid <= 1;
        rdata <= (rd_idx >= cfg_idle_at) ? 32'h0000_0002 : 32'h0000_0001;
        rresp <= (rd_idx == cfg_bad_r) ? 2'b10 : 2'b00;
      end else if (arvalid && !arready && !rvalid) arready <= 1;
      if (rvalid && rready) begin
        rvalid <= 0; rd_idx++;
      end
    end
  end

  task automatic push_exp(input logic [31:0] a, input logic [31:0] l, input int n);
    if (n >= 1) exp_q.push_back({BASE + 32'h00, 32'h0000_0001});
    if (n >= 2) exp_q.push_back({BASE + 32'h18, a});
    if (n >= 3) exp_q.push_back({BASE + 32'h28, l});
  endtask

  task automatic pulse_start(input logic [31:0] a, input logic [31:0] l);
    @(negedge clk); start = 1; src_addr = a; byte_len = l;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end(input int base_sum);
    for (int i = 0; i < 3000; i++) begin
      if (done_cnt + err_cnt > base_sum) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // Launch a valid request; expect n writes, rd reads, and given done/err counts
  task automatic launch(input logic [31:0] a, input logic [31:0] l, input int n,
                        input int nrd, input int ndone, input int nerr_exp, input string tag);
    int w0, r0, d0, e0;
    w0 = wr_idx; r0 = rd_idx; d0 = done_cnt; e0 = err_cnt;
    push_exp(a, l, n);
    pulse_start(a, l);
    check(busy == 1, {tag, " R10 busy after start"}, busy, 1);
    wait_end(d0 + e0);
    check(wr_idx - w0 == n, {tag, " R2 write count"}, wr_idx - w0, n);
    check(rd_idx - r0 == nrd, {tag, " R7 poll count"}, rd_idx - r0, nrd);
    check(done_cnt - d0 == ndone, {tag, " R7 done pulses"}, done_cnt - d0, ndone);
    check(err_cnt - e0 == nerr_exp, {tag, " R8 err pulses"}, err_cnt - e0, nerr_exp);
    check(busy == 0, {tag, " R10 busy released"}, busy, 0);
    check(exp_q.size() == 0, {tag, " R5 all writes seen"}, exp_q.size(), 0);
  endtask

  task automatic reject(input logic [31:0] l, input string tag);
    int w0, e0;
    w0 = wr_idx; e0 = err_cnt;
    pulse_start(32'h1234_0000, l);
    check(err == 1 && busy == 0, {tag, " R6 err pulse, not busy"}, {err, busy}, 2'b10);
    @(negedge clk);
    check(err == 0, {tag, " R6 err single cycle"}, err, 0);
    repeat (10) begin
      check(!awvalid && !arvalid && !busy, {tag, " R6 no transaction"}, {awvalid, arvalid, busy}, 0);
      @(negedge clk);
    end
    check(wr_idx == w0 && err_cnt - e0 == 1, {tag, " R6 counts"}, wr_idx - w0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, err, awvalid, wvalid, bready, arvalid, rready} == 0, "R1 reset outputs",
          {busy, done, err, awvalid, wvalid, bready, arvalid, rready}, 0);
    rst = 0;
    @(negedge clk);
    check({busy, done, err, awvalid, arvalid} == 0, "R1 after reset release",
          {busy, done, err, awvalid, arvalid}, 0);

    // R2 R3 R4 R5 R7 basic launch, idle on first poll
    cfg_idle_at = rd_idx;
    launch(32'h1000_0000, 32'd64, 3, 1, 1, 0, "basic");

    // R4 unaligned address, R6 largest legal length, slow address channel, 3 busy polls
    cfg_aw_lat = 3; cfg_w_lat = 0; cfg_idle_at = rd_idx + 3;
    launch(32'h2000_0003, 32'h03FF_FFFF, 3, 4, 1, 0, "unaligned");
    cfg_aw_lat = 0; cfg_w_lat = 4; cfg_idle_at = rd_idx + 1;
    launch(32'h2000_0101, 32'd5, 3, 2, 1, 0, "slow data");
    cfg_w_lat = 0;

    // R6 rejects
    reject(32'd0, "zero len");
    reject(32'h0400_0000, "len 2^26");
    reject(32'hFFFF_FFFF, "len max");

    // R8 bad write response on the second write
    cfg_bad_b = wr_idx + 1; cfg_idle_at = rd_idx;
    launch(32'h3000_0000, 32'd16, 2, 0, 0, 1, "bresp error");
    cfg_bad_b = -1;

    // R8 bad status read response
    cfg_bad_r = rd_idx + 1; cfg_idle_at = rd_idx + 5;
    launch(32'h3100_0000, 32'd32, 3, 2, 0, 1, "rresp error");
    cfg_bad_r = -1;

    // R9 start while busy mid-sequence
    begin
      int w0, d0;
      w0 = wr_idx; d0 = done_cnt;
      cfg_idle_at = rd_idx + 4;
      push_exp(32'h5000_0000, 32'd100, 3);
      pulse_start(32'h5000_0000, 32'd100);
      repeat (4) @(negedge clk);
      pulse_start(32'h6000_0000, 32'd200);
      wait_end(d0 + err_cnt);
      repeat (20) @(negedge clk);
      check(wr_idx - w0 == 3, "R9 mid-run start ignored, writes", wr_idx - w0, 3);
      check(done_cnt - d0 == 1, "R9 mid-run start ignored, done", done_cnt - d0, 1);
    end

    // R9 start in the cycle the final status response is accepted
    begin
      int w0, d0;
      w0 = wr_idx; d0 = done_cnt;
      cfg_idle_at = rd_idx + 2;
      push_exp(32'h7000_0000, 32'd8, 3);
      pulse_start(32'h7000_0000, 32'd8);
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (rvalid && rdata[1]) break;
      end
      start = 1; src_addr = 32'h7100_0000; byte_len = 32'd9;
      @(negedge clk);
      start = 0;
      repeat (30) @(negedge clk);
      check(wr_idx - w0 == 3, "R9 collision start ignored, writes", wr_idx - w0, 3);
      check(done_cnt - d0 == 1, "R9 collision done once", done_cnt - d0, 1);
      check(busy == 0, "R9 collision idle", busy, 0);
    end

    // still accepts a fresh request afterwards
    cfg_idle_at = rd_idx;
    launch(32'h8000_0004, 32'd12, 3, 1, 1, 0, "after collision");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule